// File: doc/BRIEF.md
# Mode-Split 16-bit Arithmetic Logic Unit

This block is a purely combinational 16-bit ALU. It takes two operands, a 3-bit operation code and a 1-bit mode, and returns a 16-bit result and a carry flag in the same cycle. A small decoder turns the mode and code into control signals. These pick an arithmetic operation, a bitwise function or a shift variant. Two 2-to-1 multiplexers then choose which unit drives the result.

The mode bit splits the code space. Mode 0 selects one of eight bitwise functions. Mode 1 selects either the arithmetic unit or the barrel shifter. The arithmetic unit adds, subtracts, increments, or multiplies the low bytes of the two operands. The carry flag reports an arithmetic carry only for add, subtract and increment. It is held at 0 for every other operation. The block has no clock and no state; a parent pipeline registers its outputs.

Top module: `alu16_top`

## Requirements
- R1: With op_mode = 0, op_code selects the bitwise function: 000 AND, 001 OR, 010 NAND, 011 NOR, 100 XOR, 101 XNOR, 110 NOT operand_a, 111 NOT operand_b.
- R2: With op_mode = 1 and op_code = 000, alu_result is (operand_a + operand_b) mod 2^16 and carry_out is bit 16 of the full sum.
- R3: With op_mode = 1 and op_code = 001, alu_result is (operand_a − operand_b) mod 2^16 and carry_out is 1 exactly when operand_a ≥ operand_b (unsigned).
- R4: With op_mode = 1 and op_code = 010, alu_result is (operand_a + 1) mod 2^16 and carry_out is 1 only when operand_a = 0xFFFF.
- R5: With op_mode = 1 and op_code = 011, alu_result is the 16-bit product of operand_a[7:0] and operand_b[7:0], and carry_out is 0.
- R6: With op_mode = 1 and op_code[2] = 1, operand_a is shifted by operand_b[3:0]. op_code[0] = 0 shifts left and 1 shifts right. op_code[1] = 0 is logical and 1 is arithmetic. operand_b[15:4] has no effect.
- R7: Logical shifts fill vacated bits with 0. An arithmetic right shift fills with operand_a[15]. An arithmetic left shift gives the same result as a logical left shift.
- R8: carry_out is 0 for every bitwise function and every shift.
- R9: A shift by an amount of 0 returns operand_a unchanged for all four shift variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_a | input | 16 | First operand; the value that is shifted |
| operand_b | input | 16 | Second operand; bits 3:0 give the shift amount |
| op_code | input | 3 | Operation code within the selected mode |
| op_mode | input | 1 | 0 = bitwise functions, 1 = arithmetic and shifts |
| alu_result | output | 16 | Result of the selected operation |
| carry_out | output | 1 | Arithmetic carry or no-borrow; 0 for non-arithmetic operations |

## Verification
The bench sweeps every mode and code over a grid of boundary operands: 0, 1, 0x7FFF, 0x8000, 0xFFFF and alternating patterns. This grid catches a carry that leaks out of a bitwise or shift operation, or a subtract flag that reports borrow instead of no-borrow. It also catches an increment flag that fires on values other than 0xFFFF. A separate shift sweep covers all sixteen amounts with noise in the upper operand_b bits. That sweep exposes a shifter that fills right shifts with zeros instead of the sign bit, one that reads more than four amount bits, or one that mistreats an amount of 0. Multiplies with 0xFF bytes catch a product that is truncated to 8 bits or that uses the upper operand bytes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [1:0] {
        ARITH_ADD = 2'b00,
        ARITH_SUB = 2'b01,
        ARITH_INC = 2'b10,
        ARITH_MUL = 2'b11
    } arith_sel_e;

    typedef enum logic [2:0] {
        BIT_AND  = 3'b000,
        BIT_OR   = 3'b001,
        BIT_NAND = 3'b010,
        BIT_NOR  = 3'b011,
        BIT_XOR  = 3'b100,
        BIT_XNOR = 3'b101,
        BIT_INVA = 3'b110,
        BIT_INVB = 3'b111
    } bit_sel_e;

    typedef struct packed {
        arith_sel_e arith_sel;
        bit_sel_e   bit_sel;
        logic       shift_right;
        logic       shift_arith;
        logic       pick_shift;
        logic       pick_bitwise;
        logic       carry_en;
    } alu_ctrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
    import alu16_pkg::*;
(
    input  logic       mode,
    input  logic [2:0] code,
    output alu_ctrl_t  ctrl
);

    alu_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d              = '0;
        ctrl_d.arith_sel    = arith_sel_e'(code[1:0]);
        ctrl_d.bit_sel      = bit_sel_e'(code);
        ctrl_d.shift_right  = code[0];
        ctrl_d.shift_arith  = code[1];
        ctrl_d.pick_shift   = code[2];
        ctrl_d.pick_bitwise = ~mode;
        ctrl_d.carry_en     = mode & ~code[2];
    end

    assign ctrl = ctrl_d;

    always_comb begin
        if (!$isunknown({mode, code})) begin
            AST_CARRY_ONLY_ARITH: assert (!ctrl_d.carry_en || (!ctrl_d.pick_bitwise && !ctrl_d.pick_shift))
                else $error("carry enabled outside arithmetic"); // R8
        end
    end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  arith_sel_e       sel,
    output logic [WIDTH-1:0] res,
    output logic             carry
);

    localparam int MUL_W = WIDTH / 2;

    logic [WIDTH:0]   wide_d;
    logic [WIDTH-1:0] mul_a_d;
    logic [WIDTH-1:0] mul_b_d;
    logic [WIDTH-1:0] prod_d;

    always_comb begin
        mul_a_d = {{(WIDTH - MUL_W){1'b0}}, a[MUL_W-1:0]};
        mul_b_d = {{(WIDTH - MUL_W){1'b0}}, b[MUL_W-1:0]};
        prod_d  = mul_a_d * mul_b_d;
        wide_d  = '0;
        case (sel)
            ARITH_ADD: wide_d = {1'b0, a} + {1'b0, b};
            ARITH_SUB: wide_d = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
            ARITH_INC: wide_d = {1'b0, a} + {{WIDTH{1'b0}}, 1'b1};
            default:   wide_d = {1'b0, prod_d};
        endcase
    end

    assign res   = wide_d[WIDTH-1:0];
    assign carry = wide_d[WIDTH];

    always_comb begin
        if (!$isunknown({a, b, sel})) begin
            if (sel == ARITH_SUB) begin
                AST_SUB_INVERTS: assert ((res + b) == a)
                    else $error("difference does not restore operand"); // R3
                AST_SUB_NOBORROW: assert (carry == (a >= b))
                    else $error("no-borrow flag wrong"); // R3
            end
            if (sel == ARITH_INC) begin
                AST_INC_WRAP: assert (carry == (res == '0))
                    else $error("increment carry not tied to wrap"); // R4
            end
            if (sel == ARITH_MUL) begin
                AST_MUL_NO_CARRY: assert (!carry)
                    else $error("multiply produced carry"); // R5
                AST_MUL_ZERO: assert ((a[MUL_W-1:0] != '0) || (res == '0))
                    else $error("zero byte gave nonzero product"); // R5
            end
        end
    end

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  bit_sel_e         sel,
    output logic [WIDTH-1:0] res
);

    logic [WIDTH-1:0] res_d;

    always_comb begin
        case (sel)
            BIT_AND:  res_d = a & b;
            BIT_OR:   res_d = a | b;
            BIT_NAND: res_d = ~(a & b);
            BIT_NOR:  res_d = ~(a | b);
            BIT_XOR:  res_d = a ^ b;
            BIT_XNOR: res_d = ~(a ^ b);
            BIT_INVA: res_d = ~a;
            default:  res_d = ~b;
        endcase
    end

    assign res = res_d;

    always_comb begin
        if (!$isunknown({a, b, sel})) begin
            if (sel == BIT_XNOR) begin
                AST_XNOR_PARITY: assert ((res ^ a ^ b) == '1)
                    else $error("xnor mismatch"); // R1
            end
            if (sel == BIT_NAND) begin
                AST_NAND_COVER: assert ((res | a) == '1 || (res | b) == '1)
                    else $error("nand mismatch"); // R1
            end
        end
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]         a,
    input  logic [$clog2(WIDTH)-1:0] amt,
    input  logic                     right,
    input  logic                     arith,
    output logic [WIDTH-1:0]         res
);

    localparam int STAGES = $clog2(WIDTH);

    logic             fill_d;
    logic [WIDTH-1:0] stage [STAGES+1];

    assign fill_d   = right & arith & a[WIDTH-1];
    assign stage[0] = a;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [WIDTH-1:0] nxt_d;
        always_comb begin
            if (!amt[k])
                nxt_d = stage[k];
            else if (right)
                nxt_d = {{S{fill_d}}, stage[k][WIDTH-1:S]};
            else
                nxt_d = {stage[k][WIDTH-1-S:0], {S{1'b0}}};
        end
        assign stage[k+1] = nxt_d;
    end

    assign res = stage[STAGES];

    always_comb begin
        if (!$isunknown({a, amt, right, arith})) begin
            if (amt != '0 && !right) begin
                AST_LEFT_ZERO_FILL: assert (!res[0])
                    else $error("left shift did not clear lsb"); // R7
            end
            if (amt != '0 && right && arith) begin
                AST_SIGN_FILL: assert (res[WIDTH-1] == a[WIDTH-1])
                    else $error("arithmetic right lost sign"); // R7
            end
            if (amt != '0 && right && !arith) begin
                AST_RIGHT_ZERO_FILL: assert (!res[WIDTH-1])
                    else $error("logical right did not clear msb"); // R7
            end
        end
    end

endmodule

// File: rtl/alu16_mux2.sv
module alu16_mux2 #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] in0,
    input  logic [WIDTH-1:0] in1,
    input  logic             sel,
    output logic [WIDTH-1:0] out
);

    assign out = sel ? in1 : in0;

endmodule

// File: rtl/alu16_top.sv
module alu16_top
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] operand_a,
    input  logic [WIDTH-1:0] operand_b,
    input  logic [2:0]       op_code,
    input  logic             op_mode,
    output logic [WIDTH-1:0] alu_result,
    output logic             carry_out
);

    localparam int AMT_W = $clog2(WIDTH);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] arith_res;
    logic             arith_carry;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] shift_res;
    logic [WIDTH-1:0] upper_res;

    alu16_ctrl u_ctrl (
        .mode (op_mode),
        .code (op_code),
        .ctrl (ctrl)
    );

    alu16_arith #(.WIDTH(WIDTH)) u_arith (
        .a     (operand_a),
        .b     (operand_b),
        .sel   (ctrl.arith_sel),
        .res   (arith_res),
        .carry (arith_carry)
    );

    alu16_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a   (operand_a),
        .b   (operand_b),
        .sel (ctrl.bit_sel),
        .res (bit_res)
    );

    alu16_shift #(.WIDTH(WIDTH)) u_shift (
        .a     (operand_a),
        .amt   (operand_b[AMT_W-1:0]),
        .right (ctrl.shift_right),
        .arith (ctrl.shift_arith),
        .res   (shift_res)
    );

    alu16_mux2 #(.WIDTH(WIDTH)) u_mux_upper (
        .in0 (arith_res),
        .in1 (shift_res),
        .sel (ctrl.pick_shift),
        .out (upper_res)
    );

    alu16_mux2 #(.WIDTH(WIDTH)) u_mux_final (
        .in0 (upper_res),
        .in1 (bit_res),
        .sel (ctrl.pick_bitwise),
        .out (alu_result)
    );

    assign carry_out = ctrl.carry_en & arith_carry;

    always_comb begin
        if (!$isunknown({operand_a, operand_b, op_code, op_mode})) begin
            if (!op_mode || op_code[2]) begin
                AST_NO_STRAY_CARRY: assert (!carry_out)
                    else $error("carry set on non-arithmetic op"); // R8
            end
            if (op_mode && op_code[2] && operand_b[AMT_W-1:0] == '0) begin
                AST_SHIFT_ZERO_IDENT: assert (alu_result == operand_a)
                    else $error("zero shift altered operand"); // R9
            end
        end
    end

endmodule

// File: tb/tb_alu16_top.sv
module tb_alu16_top;

    logic        clk = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [2:0]  code = '0;
    logic        mode = 1'b0;
    logic [15:0] res;
    logic        cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu16_top dut (
        .operand_a  (a),
        .operand_b  (b),
        .op_code    (code),
        .op_mode    (mode),
        .alu_result (res),
        .carry_out  (cout)
    );

    function automatic logic [15:0] pat(input int i);
        case (i)
            0: pat = 16'h0000;  1: pat = 16'h0001;  2: pat = 16'h0002;  3: pat = 16'h7FFF;
            4: pat = 16'h8000;  5: pat = 16'h8001;  6: pat = 16'hFFFF;  7: pat = 16'hFFFE;
            8: pat = 16'h00FF;  9: pat = 16'hFF00; 10: pat = 16'hAAAA; 11: pat = 16'h5555;
            12: pat = 16'h1234; 13: pat = 16'h0F0F; 14: pat = 16'hF00F; default: pat = 16'h80C7;
        endcase
    endfunction

    // expected {cout, result}
    function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y,
                                          input logic m, input logic [2:0] c);
        int unsigned n;
        logic [15:0] r;
        logic        k;
        n = y[3:0];
        k = 1'b0;
        if (!m) begin
            case (c)
                3'd0: r = x & y;      3'd1: r = x | y;
                3'd2: r = ~(x & y);   3'd3: r = ~(x | y);
                3'd4: r = x ^ y;      3'd5: r = ~(x ^ y);
                3'd6: r = ~x;         default: r = ~y;
            endcase
        end else begin
            case (c)
                3'd0: begin r = 16'((32'(x) + 32'(y)) % 65536); k = (32'(x) + 32'(y)) > 32'd65535; end
                3'd1: begin r = 16'((32'(x) + 65536 - 32'(y)) % 65536); k = (x >= y); end
                3'd2: begin r = 16'((32'(x) + 1) % 65536); k = (x == 16'hFFFF); end
                3'd3: r = 16'(32'(x[7:0]) * 32'(y[7:0]));
                3'd4, 3'd6: r = 16'((32'(x) * (32'd1 << n)) % 65536);
                3'd5: r = 16'(32'(x) / (32'd1 << n));
                default: r = 16'(32'(x) / (32'd1 << n)) | (x[15] ? ~16'(32'hFFFF / (32'd1 << n)) : 16'h0);
            endcase
        end
        model = {k, r};
    endfunction

    function automatic string tag(input logic m, input logic [2:0] c, input logic [3:0] n);
        if (!m) tag = "R1";
        else if (c == 3'd0) tag = "R2";
        else if (c == 3'd1) tag = "R3";
        else if (c == 3'd2) tag = "R4";
        else if (c == 3'd3) tag = "R5";
        else if (n == 4'd0) tag = "R9";
        else if (c == 3'd7 || c == 3'd6) tag = "R7";
        else tag = "R6";
    endfunction

    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic m, input logic [2:0] c);
        logic [16:0] exp;
        string t;
        @(posedge clk);
        a = x; b = y; mode = m; code = c;
        @(negedge clk);
        exp = model(x, y, m, c);
        t = tag(m, c, y[3:0]);
        checks++;
        if (res !== exp[15:0]) begin
            fails++;
            $display("FAIL %s result a=%h b=%h mode=%0d op=%0d actual=%h expected=%h",
                     t, x, y, m, c, res, exp[15:0]);
        end
        checks++;
        if (cout !== exp[16]) begin
            fails++;
            $display("FAIL %s carry a=%h b=%h mode=%0d op=%0d actual=%0d expected=%0d",
                     (!m || c[2]) ? "R8" : t, x, y, m, c, cout, exp[16]);
        end
    endtask

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // initial state: all-zero inputs give AND of zeros, no carry (R1, R8)
        @(negedge clk);
        checks++;
        if (res !== 16'h0 || cout !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle actual=%h/%0d expected=0000/0", res, cout);
        end
        // full grid over modes and codes
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 8; c++)
                for (int i = 0; i < 16; i++)
                    for (int j = 0; j < 16; j++)
                        apply(pat(i), pat(j), m[0], c[2:0]);
        // shift sweep: every amount, noisy upper bits in operand_b (R6, R7, R9)
        for (int c = 4; c < 8; c++)
            for (int n = 0; n < 16; n++)
                for (int i = 3; i < 16; i += 3)
                    apply(pat(i), 16'hA5A0 | 16'(n) | 16'(i << 8), 1'b1, c[2:0]);
        // multiply byte extremes (R5)
        apply(16'h12FF, 16'h34FF, 1'b1, 3'd3);
        apply(16'hFF80, 16'h0002, 1'b1, 3'd3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule